// File: doc/BRIEF.md
# Cyclo-static actor firing sequencer

This block sequences one dataflow actor whose token consumption and production rates change from firing to firing in a fixed repeating pattern. It holds a small table of per-phase rates and a phase pointer. It also holds two token counters: one for the actor's input channel and one for its output channel. Whenever the input channel holds enough tokens for the current phase and the output channel has room for that phase's production, the block issues a one-cycle fire pulse tagged with the phase number. It then waits for the actor to report completion.

On completion the block subtracts the phase's consumption from the input counter, adds the phase's production to the output counter, and moves to the next phase. The pointer wraps after the last configured phase. Upstream logic adds input tokens one per cycle and downstream logic removes output tokens one per cycle, through simple strobes. The rate table and the number of phases are written through a configuration port. That port only takes effect while no firing is outstanding.

Top module: `cyclo_fire_ctrl`

## Requirements
- R1: After reset, both token counters are 0, the phase is 0, fire and busy are low, and there is a single phase (last index 0). Every table entry holds consumption 1 and production 1.
- R2: While busy is low, cfgWrEn writes consumption cfgCons and production cfgProd into entry cfgAddr. Also while busy is low, cfgLenWe sets the last phase index to cfgLastIdx and returns the phase to 0. While busy is high, both writes are ignored. No firing starts in a cycle in which either write strobe is high.
- R3: A firing starts at a clock edge only when all of the following hold: busy is low, no configuration strobe is high, inCount is at least the current phase's consumption, and outCount plus the current phase's production is at most 255. In the cycle after that edge, fire and busy are high and firePhase shows the phase.
- R4: fire is high for exactly one cycle per firing. No further firing starts until completion.
- R5: At an edge with busy and actDone both high, the current phase's consumption is subtracted from inCount and its production is added to outCount. At the same edge the phase advances and busy clears.
- R6: The phase advances by one per completed firing and returns to 0 after the last index. With a last index of 0 the phase stays 0. firePhase does not change while a firing is outstanding.
- R7: fullStall is high while busy is low, the input has enough tokens, and the production would take outCount above 255. No firing starts in that condition, and it clears once enough output tokens are removed.
- R8: inPush adds one token to inCount and is ignored when inCount is 255. inPush combines with a completion in the same cycle.
- R9: outPop removes one token from outCount and is ignored when outCount is 0. outPop combines with a completion in the same cycle.
- R10: A phase with consumption 0 fires with an empty input channel. A phase with production 0 leaves outCount unchanged at completion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfgWrEn | input | 1 | Write strobe for one rate table entry |
| cfgAddr | input | 3 | Table entry selected by cfgWrEn |
| cfgCons | input | 4 | Consumption count to store |
| cfgProd | input | 4 | Production count to store |
| cfgLenWe | input | 1 | Write strobe for the last phase index |
| cfgLastIdx | input | 3 | Last phase index (phase count minus one) |
| inPush | input | 1 | Adds one token to the input channel |
| outPop | input | 1 | Removes one token from the output channel |
| actDone | input | 1 | Actor reports completion of the outstanding firing |
| fire | output | 1 | One-cycle pulse starting a firing |
| firePhase | output | 3 | Current phase index |
| busy | output | 1 | A firing is outstanding |
| fullStall | output | 1 | Firing held back because the output channel would overflow |
| inCount | output | 8 | Input channel token count |
| outCount | output | 8 | Output channel token count |

## Verification
The sequencer is exercised under several rate tables:
- The reset table shows the default rates.
- A three-phase table mixes a two-token phase, a zero-consumption phase and a zero-production phase. It separates correct per-phase rate lookup from a fixed rate, and correct wrap from a free-running pointer.
- A single-phase table with zero consumption and maximum production drives the output counter to 255. This exposes overflow guarding and the stall release after output tokens are removed.

Completions coincide with pushes and pops to show that the counter updates combine. Configuration writes issued during a firing, and a length write issued just as a zero-consumption phase would fire, show that writes are gated while busy and that a length write holds off firing and resets the phase.

// File: rtl/cyclo_fire_pkg.sv
package cyclo_fire_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } fireState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic launch;   // a firing starts at this edge
    logic commit;   // outstanding firing completes at this edge
    logic cfgOk;    // configuration writes may land
  } ctrlStrobe_t;

endpackage

// File: rtl/cyclo_fire_dp.sv
module cyclo_fire_dp
  import cyclo_fire_pkg::*;
#(
  parameter int PHASES = 8,
  parameter int RATE_W = 4,
  parameter int CNT_W  = 8,
  localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobe_t       strb,
  input  logic              cfgWrEn,
  input  logic [PH_W-1:0]   cfgAddr,
  input  logic [RATE_W-1:0] cfgCons,
  input  logic [RATE_W-1:0] cfgProd,
  input  logic              cfgLenWe,
  input  logic [PH_W-1:0]   cfgLastIdx,
  input  logic              inPush,
  input  logic              outPop,
  output logic [PH_W-1:0]   phase,
  output logic [CNT_W-1:0]  inCount,
  output logic [CNT_W-1:0]  outCount,
  output logic              canFire,
  output logic              outBlocked
);

  localparam logic [CNT_W-1:0] CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [CNT_W:0]   SUM_MAX  = {1'b0, CNT_MAX};

  logic [PHASES-1:0][RATE_W-1:0] consTab;
  logic [PHASES-1:0][RATE_W-1:0] prodTab;
  logic [PH_W-1:0]   lastIdx;
  logic [RATE_W-1:0] curCons;
  logic [RATE_W-1:0] curProd;
  logic [CNT_W:0]    outSum;
  logic              haveIn;
  logic              fits;
  logic [CNT_W-1:0]  inNext;
  logic [CNT_W-1:0]  outNext;

  // rate table
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int e = 0; e < PHASES; e++) begin
        consTab[e] <= RATE_W'(1);
        prodTab[e] <= RATE_W'(1);
      end
    end else if (strb.cfgOk && cfgWrEn) begin
      for (int e = 0; e < PHASES; e++) begin
        if (cfgAddr == PH_W'(e)) begin
          consTab[e] <= cfgCons;
          prodTab[e] <= cfgProd;
        end
      end
    end
  end

  assign curCons = consTab[phase];
  assign curProd = prodTab[phase];

  // enable and overflow decisions
  assign outSum     = {1'b0, outCount} + (CNT_W+1)'(curProd);
  assign fits       = (outSum <= SUM_MAX);
  assign haveIn     = (inCount >= CNT_W'(curCons));
  assign canFire    = haveIn && fits;
  assign outBlocked = haveIn && !fits;

  // token counter next values
  always_comb begin
    inNext = inCount;
    if (strb.commit) inNext = inNext - CNT_W'(curCons);
    if (inPush && (inCount != CNT_MAX)) inNext = inNext + CNT_W'(1);
  end

  always_comb begin
    outNext = outCount;
    if (strb.commit) outNext = outNext + CNT_W'(curProd);
    if (outPop && (outCount != '0)) outNext = outNext - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inCount  <= '0;
      outCount <= '0;
    end else begin
      inCount  <= inNext;
      outCount <= outNext;
    end
  end

  // phase pointer and cycle length
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= '0;
      lastIdx <= '0;
    end else if (strb.commit) begin
      phase <= (phase == lastIdx) ? '0 : phase + PH_W'(1);
    end else if (strb.cfgOk && cfgLenWe) begin
      lastIdx <= cfgLastIdx;
      phase   <= '0;
    end
  end

endmodule

// File: rtl/cyclo_fire_fsm.sv
module cyclo_fire_fsm
  import cyclo_fire_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        canFire,
  input  logic        outBlocked,
  input  logic        cfgWrEn,
  input  logic        cfgLenWe,
  input  logic        actDone,
  output ctrlStrobe_t strb,
  output logic        fire,
  output logic        busy,
  output logic        fullStall
);

  fireState_t state;

  assign busy = (state == ST_RUN);

  always_comb begin
    strb.launch = (state == ST_IDLE) && canFire && !cfgWrEn && !cfgLenWe;
    strb.commit = (state == ST_RUN) && actDone;
    strb.cfgOk  = (state == ST_IDLE);
  end

  assign fullStall = (state == ST_IDLE) && outBlocked;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      fire  <= 1'b0;
    end else begin
      fire <= strb.launch;
      if (strb.launch)      state <= ST_RUN;
      else if (strb.commit) state <= ST_IDLE;
    end
  end

endmodule

// File: rtl/cyclo_fire_ctrl.sv
module cyclo_fire_ctrl
  import cyclo_fire_pkg::*;
#(
  parameter int PHASES = 8,
  parameter int RATE_W = 4,
  parameter int CNT_W  = 8,
  localparam int PH_W  = (PHASES > 1) ? $clog2(PHASES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [PH_W-1:0]   cfgAddr,
  input  logic [RATE_W-1:0] cfgCons,
  input  logic [RATE_W-1:0] cfgProd,
  input  logic              cfgLenWe,
  input  logic [PH_W-1:0]   cfgLastIdx,
  input  logic              inPush,
  input  logic              outPop,
  input  logic              actDone,
  output logic              fire,
  output logic [PH_W-1:0]   firePhase,
  output logic              busy,
  output logic              fullStall,
  output logic [CNT_W-1:0]  inCount,
  output logic [CNT_W-1:0]  outCount
);

  ctrlStrobe_t strb;
  logic        canFire;
  logic        outBlocked;

  cyclo_fire_fsm u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .canFire    (canFire),
    .outBlocked (outBlocked),
    .cfgWrEn    (cfgWrEn),
    .cfgLenWe   (cfgLenWe),
    .actDone    (actDone),
    .strb       (strb),
    .fire       (fire),
    .busy       (busy),
    .fullStall  (fullStall)
  );

  cyclo_fire_dp #(
    .PHASES (PHASES),
    .RATE_W (RATE_W),
    .CNT_W  (CNT_W)
  ) u_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strb       (strb),
    .cfgWrEn    (cfgWrEn),
    .cfgAddr    (cfgAddr),
    .cfgCons    (cfgCons),
    .cfgProd    (cfgProd),
    .cfgLenWe   (cfgLenWe),
    .cfgLastIdx (cfgLastIdx),
    .inPush     (inPush),
    .outPop     (outPop),
    .phase      (firePhase),
    .inCount    (inCount),
    .outCount   (outCount),
    .canFire    (canFire),
    .outBlocked (outBlocked)
  );

endmodule

// File: rtl/cyclo_fire_chk.sv
module cyclo_fire_chk #(
  parameter int CNT_W = 8,
  parameter int PH_W  = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fire,
  input logic             busy,
  input logic             actDone,
  input logic             cfgWrEn,
  input logic             cfgLenWe,
  input logic             inPush,
  input logic             outPop,
  input logic             fullStall,
  input logic [PH_W-1:0]  firePhase,
  input logic [CNT_W-1:0] inCount,
  input logic [CNT_W-1:0] outCount
);

  AST_CFG_HOLDS_FIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && (cfgWrEn || cfgLenWe)) |=> !fire);                       // R2
  AST_FIRE_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> busy);                                                    // R3
  AST_FIRE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !fire);                                                   // R4
  AST_DONE_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && actDone) |=> !busy);                                      // R5
  AST_PHASE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !actDone) |=> $stable(firePhase));                        // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    fullStall |=> !fire);                                              // R7
  AST_IN_NO_GROWTH: assert property (@(posedge clk) disable iff (!rst_n)
    !inPush |=> (inCount <= $past(inCount)));                          // R8
  AST_OUT_NO_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
    !outPop |=> (outCount >= $past(outCount)));                        // R9

endmodule

bind cyclo_fire_ctrl cyclo_fire_chk #(.CNT_W(CNT_W), .PH_W(PH_W)) i_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .fire      (fire),
  .busy      (busy),
  .actDone   (actDone),
  .cfgWrEn   (cfgWrEn),
  .cfgLenWe  (cfgLenWe),
  .inPush    (inPush),
  .outPop    (outPop),
  .fullStall (fullStall),
  .firePhase (firePhase),
  .inCount   (inCount),
  .outCount  (outCount)
);

// File: tb/test_cyclo_fire_ctrl.sv
module test_cyclo_fire_ctrl;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       cfgWrEn, cfgLenWe, inPush, outPop, actDone;
  logic [2:0] cfgAddr, cfgLastIdx;
  logic [3:0] cfgCons, cfgProd;
  logic       fire, busy, fullStall;
  logic [2:0] firePhase;
  logic [7:0] inCount, outCount;

  int compared   = 0;
  int mismatched = 0;
  int expQ[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  cyclo_fire_ctrl i_cyclo_fire_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfgWrEn(cfgWrEn), .cfgAddr(cfgAddr), .cfgCons(cfgCons), .cfgProd(cfgProd),
    .cfgLenWe(cfgLenWe), .cfgLastIdx(cfgLastIdx),
    .inPush(inPush), .outPop(outPop), .actDone(actDone),
    .fire(fire), .firePhase(firePhase), .busy(busy), .fullStall(fullStall),
    .inCount(inCount), .outCount(outCount)
  );

  task automatic chk(input string tag, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: every fire pulse must match the next expected phase
  always @(negedge clk) begin : mon
    int e;
    if (rst_n && fire) begin
      if (expQ.size() == 0) chk("R3 unexpected fire, phase", int'(firePhase), -1);
      else begin
        e = expQ.pop_front();
        chk("R6 fire phase", int'(firePhase), e);
      end
    end
  end

  task automatic cfgWr(input int a, input int c, input int p);
    cfgWrEn = 1'b1; cfgAddr = 3'(a); cfgCons = 4'(c); cfgProd = 4'(p);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  task automatic cfgLen(input int l);
    cfgLenWe = 1'b1; cfgLastIdx = 3'(l);
    @(negedge clk);
    cfgLenWe = 1'b0;
  endtask

  task automatic pushN(input int n);
    for (int k = 0; k < n; k++) begin inPush = 1'b1; @(negedge clk); end
    inPush = 1'b0;
  endtask

  task automatic popN(input int n);
    for (int k = 0; k < n; k++) begin outPop = 1'b1; @(negedge clk); end
    outPop = 1'b0;
  endtask

  task automatic waitFire();
    int n = 0;
    while (!fire && n < 40) begin @(negedge clk); n++; end
    if (!fire) chk("R3 fire timeout", 0, 1);
  endtask

  task automatic finishDone();
    actDone = 1'b1;
    @(negedge clk);
    actDone = 1'b0;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk("watchdog expired", 0, 1);
    summary();
  end

  initial begin
    rst_n = 1'b0; cfgWrEn = 0; cfgLenWe = 0; inPush = 0; outPop = 0; actDone = 0;
    cfgAddr = 0; cfgLastIdx = 0; cfgCons = 0; cfgProd = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 inCount", inCount, 0);
    chk("R1 outCount", outCount, 0);
    chk("R1 busy", busy, 0);
    chk("R1 firePhase", firePhase, 0);
    chk("R1 fullStall", fullStall, 0);

    // default table: consumption 1, production 1, one phase
    expQ.push_back(0);
    pushN(1);
    waitFire();
    chk("R3 busy at fire", busy, 1);
    chk("R1 inCount at fire", inCount, 1);
    finishDone();
    chk("R4 fire pulse ended", fire, 0);
    chk("R5 inCount after done", inCount, 0);
    chk("R1 default production", outCount, 1);
    chk("R5 busy cleared", busy, 0);
    chk("R6 single phase stays 0", firePhase, 0);

    // three phases: (2,3) (0,1) (3,0)
    cfgWr(0, 2, 3); cfgWr(1, 0, 1); cfgWr(2, 3, 0); cfgLen(2);
    expQ.push_back(0);
    pushN(2);
    waitFire();
    chk("R3 inCount at fire", inCount, 2);
    expQ.push_back(1);
    finishDone();
    chk("R5 inCount", inCount, 0);
    chk("R5 outCount", outCount, 4);
    chk("R6 phase advanced", firePhase, 1);
    waitFire();
    chk("R10 fired with empty input", inCount, 0);
    finishDone();
    chk("R10 outCount", outCount, 5);
    chk("R6 phase 2", firePhase, 2);

    expQ.push_back(2);
    pushN(3);
    waitFire();
    chk("R3 inCount phase 2", inCount, 3);
    actDone = 1'b1; inPush = 1'b1; outPop = 1'b1;
    @(negedge clk);
    actDone = 1'b0; inPush = 1'b0; outPop = 1'b0;
    chk("R8 push with done", inCount, 1);
    chk("R9 pop with done, R10 zero production", outCount, 4);
    chk("R6 wrap to 0", firePhase, 0);

    repeat (3) @(negedge clk);
    chk("R3 short input holds", busy, 0);

    // length write just as zero-consumption phase would fire
    expQ.push_back(0);
    pushN(1);
    waitFire();
    finishDone();
    cfgLenWe = 1'b1; cfgLastIdx = 3'd2;
    chk("R5 outCount", outCount, 7);
    chk("R6 phase 1", firePhase, 1);
    @(negedge clk);
    cfgLenWe = 1'b0;
    chk("R2 length write resets phase", firePhase, 0);
    repeat (2) @(negedge clk);
    chk("R2 firing held", busy, 0);

    popN(8);
    chk("R9 pop floor at 0", outCount, 0);

    // single phase: consumption 0, production 15
    cfgWr(0, 0, 15); cfgLen(0);
    for (int i = 0; i < 17; i++) begin
      expQ.push_back(0);
      waitFire();
      if (i == 0) begin
        cfgWrEn = 1'b1; cfgAddr = 3'd0; cfgCons = 4'd0; cfgProd = 4'd1;
        cfgLenWe = 1'b1; cfgLastIdx = 3'd3;
      end
      actDone = 1'b1;
      @(negedge clk);
      actDone = 1'b0; cfgWrEn = 1'b0; cfgLenWe = 1'b0;
      if (i == 0) begin
        chk("R2 busy write ignored, production", outCount, 15);
        chk("R2 busy write ignored, length", firePhase, 0);
      end
    end
    chk("R5 outCount at 255", outCount, 255);
    @(negedge clk);
    chk("R7 fullStall", fullStall, 1);
    repeat (3) @(negedge clk);
    chk("R7 no firing", busy, 0);
    pushN(260);
    chk("R8 push saturates", inCount, 255);
    popN(14);
    chk("R7 still stalled at 241", fullStall, 1);
    expQ.push_back(0);
    popN(1);
    waitFire();
    chk("R7 released at 240", outCount, 240);
    finishDone();
    chk("R5 outCount back to 255", outCount, 255);
    repeat (2) @(negedge clk);
    chk("R3 all expected firings seen", expQ.size(), 0);
    summary();
  end

endmodule